// File: doc/BRIEF.md
# Receive Address Filter and Interrupt Vector Encoder

This block sits next to an asynchronous serial receiver and decides which received characters reach the receive buffer. A programmable compare byte is checked against incoming characters in one of three recognition modes: the ninth bit flags an address, the first character after a line break is an address, or every character is searched. In the two addressed modes, data characters are forwarded only after an address has matched. In search mode, every character passes and a match only raises a flag.

The block also builds an 8-bit interrupt vector. Five high bits come from a software-written base, two bits give the highest-priority active interrupt source, and bit 0 is always zero. Software sets the compare byte, the vector base and the mode through a small write port. It can also clear the address-pending flag with a strobe.

Top module: `rx_addr_filter`

## Requirements
- R1: After a synchronous reset, `addr_pend`, `data_fwd` and `irq_vec` are all zero. The mode is ninth-bit mode (code 0) and the compare byte is 0x00.
- R2: A write with `cfg_we` high loads one register, chosen by `cfg_sel`: 0 loads the compare byte from `cfg_wdata[7:0]`; 1 loads the vector base from `cfg_wdata[7:3]`; 2 loads the mode from `cfg_wdata[1:0]`. The new value takes effect from the next clock edge.
- R3: In ninth-bit mode (code 0), a character with `rx_bit8`=1 is an address. An equal address sets `addr_pend` one cycle later, and an unequal address clears it. Address characters never pulse `data_fwd`.
- R4: In the addressed modes (codes 0 and 1), a data character pulses `data_fwd` one cycle after `rx_valid` only while `addr_pend` is set. Otherwise the character is dropped.
- R5: In after-break mode (code 1), `brk_det` arms the filter. The next character is then an address, whatever `rx_bit8` is, and the characters after it are data.
- R6: In search mode (codes 2 and 3), every character pulses `data_fwd`. A character equal to the compare byte sets `addr_pend`, and an unequal character leaves the flag unchanged.
- R7: `pend_clr` clears `addr_pend` on the next edge. If an address match occurs in the same cycle, the match wins and the flag stays set.
- R8: `irq_vec` is {base[4:0], source code[1:0], 1'b0}.
- R9: The source code is set from the inputs of the previous cycle, in fixed priority: any `rx_err` bit gives 00; a break or an address match gives 01; a forwarded character or `rx_dma_eob` gives 10; `tx_empty` or `tx_dma_eob` gives 11.
- R10: In a cycle with no active source, the source code keeps its previous value.
- R11: A write to the mode register clears `addr_pend` and the break-armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 2 | Register select: 0 compare, 1 vector base, 2 mode |
| cfg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | A received character is present this cycle |
| rx_data | input | 8 | Received character |
| rx_bit8 | input | 1 | Ninth bit of the received character |
| brk_det | input | 1 | Break-detected strobe |
| rx_err | input | 3 | Overrun, framing and parity error flags |
| rx_dma_eob | input | 1 | Receive DMA end-of-block strobe |
| tx_empty | input | 1 | Transmit buffer or shift register empty |
| tx_dma_eob | input | 1 | Transmit DMA end-of-block strobe |
| pend_clr | input | 1 | Software clear of the address-pending flag |
| addr_pend | output | 1 | Address matched, so data is being accepted |
| data_fwd | output | 1 | Gated data-valid strobe toward the receive buffer |
| irq_vec | output | 8 | Encoded interrupt vector |

## Verification
Ninth-bit traffic is applied as data before any address, then a matching address, then a mismatching address. This separates the gating on the ninth bit from the gating on the pending flag. After-break traffic sends the same byte once without a break and once after a break, which shows that position, not the ninth bit, makes a character an address. Search traffic sends mismatching characters before and after a match, which shows that a mismatch does not clear the flag in that mode. Each source is raised together with sources of lower priority, and then a cycle with no source follows, which exposes the priority order and the hold of the source code.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
    localparam int DATA_W = 8;
    localparam int BASE_W = 5;
    localparam int SRC_W  = 2;
    localparam int ERR_W  = 3;

    typedef enum logic [1:0] {
        MODE_NINTH  = 2'd0,
        MODE_BREAK  = 2'd1,
        MODE_SEARCH = 2'd2,
        MODE_SRCH2  = 2'd3
    } match_mode_e;

    localparam logic [SRC_W-1:0] SRC_ERR   = 2'd0;
    localparam logic [SRC_W-1:0] SRC_ADDR  = 2'd1;
    localparam logic [SRC_W-1:0] SRC_RXDAT = 2'd2;
    localparam logic [SRC_W-1:0] SRC_TX    = 2'd3;

    localparam logic [1:0] SEL_CMP  = 2'd0;
    localparam logic [1:0] SEL_BASE = 2'd1;
    localparam logic [1:0] SEL_MODE = 2'd2;
endpackage

// File: rtl/rxaf_regs.sv
module rxaf_regs
    import rxaf_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [DATA_W-1:0]       cfg_wdata,
    output logic [DATA_W-1:0]       cmp_q,
    output logic [BASE_W-1:0]       base_q,
    output match_mode_e             mode_q,
    output logic                    mode_wr
);
    typedef struct packed {
        logic [DATA_W-1:0] cmp;
        logic [BASE_W-1:0] base;
        match_mode_e       mode;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        mode_wr = 1'b0;
        if (cfg_we) begin
            unique case (cfg_sel)
                SEL_CMP:  r_d.cmp  = cfg_wdata;
                SEL_BASE: r_d.base = cfg_wdata[DATA_W-1 -: BASE_W];
                SEL_MODE: begin
                    r_d.mode = match_mode_e'(cfg_wdata[1:0]);
                    mode_wr  = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{cmp: '0, base: '0, mode: MODE_NINTH};
        end else begin
            r_q <= r_d;
        end
    end

    assign cmp_q  = r_q.cmp;
    assign base_q = r_q.base;
    assign mode_q = r_q.mode;

    // R2
    cmp_load_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_sel == SEL_CMP) |=> (cmp_q == $past(cfg_wdata)));
endmodule

// File: rtl/rxaf_match.sv
module rxaf_match
    import rxaf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  match_mode_e         mode_q,
    input  logic                mode_wr,
    input  logic [DATA_W-1:0]   cmp_q,
    input  logic                rx_valid,
    input  logic [DATA_W-1:0]   rx_data,
    input  logic                rx_bit8,
    input  logic                brk_det,
    input  logic                pend_clr,
    output logic                addr_pend,
    output logic                data_fwd,
    output logic                match_ev,
    output logic                fwd_ev
);
    typedef struct packed {
        logic pend;
        logic armed;
        logic fwd;
    } filt_t;

    filt_t f_d, f_q;
    logic  search_mode;
    logic  is_addr;
    logic  hit;

    always_comb begin
        search_mode = (mode_q == MODE_SEARCH) || (mode_q == MODE_SRCH2);
        unique case (mode_q)
            MODE_NINTH: is_addr = rx_bit8;
            MODE_BREAK: is_addr = f_q.armed;
            default:    is_addr = 1'b1;
        endcase
        hit = rx_valid && is_addr && (rx_data == cmp_q);

        f_d     = f_q;
        f_d.fwd = rx_valid && (search_mode || (!is_addr && f_q.pend));

        if (pend_clr) f_d.pend = 1'b0;
        if (rx_valid && is_addr) begin
            if (hit)               f_d.pend = 1'b1;
            else if (!search_mode) f_d.pend = 1'b0;
        end

        if (rx_valid && f_q.armed) f_d.armed = 1'b0;
        if (brk_det && mode_q == MODE_BREAK) f_d.armed = 1'b1;

        if (mode_wr) begin
            f_d.pend  = 1'b0;
            f_d.armed = 1'b0;
        end

        match_ev = hit;
        fwd_ev   = f_d.fwd;
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    assign addr_pend = f_q.pend;
    assign data_fwd  = f_q.fwd;

    // R4
    fwd_needs_char_chk: assert property (@(posedge clk) disable iff (rst)
        data_fwd |-> $past(rx_valid));

    // R3
    addr_not_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_bit8 && mode_q == MODE_NINTH && !mode_wr) |=> !data_fwd);

    // R7
    clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (pend_clr && !rx_valid) |=> !addr_pend);

    // R11
    mode_wr_clr_chk: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> !addr_pend);
endmodule

// File: rtl/rxaf_vector.sv
module rxaf_vector
    import rxaf_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [BASE_W-1:0]   base_q,
    input  logic [ERR_W-1:0]    rx_err,
    input  logic                brk_det,
    input  logic                match_ev,
    input  logic                fwd_ev,
    input  logic                rx_dma_eob,
    input  logic                tx_empty,
    input  logic                tx_dma_eob,
    output logic [DATA_W-1:0]   irq_vec
);
    typedef struct packed {
        logic [SRC_W-1:0] code;
    } vec_t;

    vec_t v_d, v_q;
    logic any_src;

    always_comb begin
        v_d     = v_q;
        any_src = 1'b1;
        if (|rx_err)                     v_d.code = SRC_ERR;
        else if (brk_det || match_ev)    v_d.code = SRC_ADDR;
        else if (fwd_ev || rx_dma_eob)   v_d.code = SRC_RXDAT;
        else if (tx_empty || tx_dma_eob) v_d.code = SRC_TX;
        else                             any_src  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) v_q <= '0;
        else     v_q <= v_d;
    end

    assign irq_vec = {base_q, v_q.code, 1'b0};

    // R9
    err_first_chk: assert property (@(posedge clk) disable iff (rst)
        (|rx_err) |=> (irq_vec[2:1] == SRC_ERR));

    // R10
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !any_src |=> $stable(irq_vec[2:1]));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
    import rxaf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_sel,
    input  logic [7:0]  cfg_wdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_bit8,
    input  logic        brk_det,
    input  logic [2:0]  rx_err,
    input  logic        rx_dma_eob,
    input  logic        tx_empty,
    input  logic        tx_dma_eob,
    input  logic        pend_clr,
    output logic        addr_pend,
    output logic        data_fwd,
    output logic [7:0]  irq_vec
);
    logic [DATA_W-1:0] cmp_q;
    logic [BASE_W-1:0] base_q;
    match_mode_e       mode_q;
    logic              mode_wr;
    logic              match_ev;
    logic              fwd_ev;

    rxaf_regs u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cmp_q(cmp_q), .base_q(base_q),
        .mode_q(mode_q), .mode_wr(mode_wr)
    );

    rxaf_match u_match (
        .clk(clk), .rst(rst), .mode_q(mode_q), .mode_wr(mode_wr),
        .cmp_q(cmp_q), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_bit8(rx_bit8), .brk_det(brk_det), .pend_clr(pend_clr),
        .addr_pend(addr_pend), .data_fwd(data_fwd),
        .match_ev(match_ev), .fwd_ev(fwd_ev)
    );

    rxaf_vector u_vector (
        .clk(clk), .rst(rst), .base_q(base_q), .rx_err(rx_err),
        .brk_det(brk_det), .match_ev(match_ev), .fwd_ev(fwd_ev),
        .rx_dma_eob(rx_dma_eob), .tx_empty(tx_empty),
        .tx_dma_eob(tx_dma_eob), .irq_vec(irq_vec)
    );
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we;
    logic [1:0] cfg_sel;
    logic [7:0] cfg_wdata;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_bit8;
    logic       brk_det;
    logic [2:0] rx_err;
    logic       rx_dma_eob;
    logic       tx_empty;
    logic       tx_dma_eob;
    logic       pend_clr;
    logic       addr_pend;
    logic       data_fwd;
    logic [7:0] irq_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rx_addr_filter u_rx_addr_filter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_bit8(rx_bit8), .brk_det(brk_det), .rx_err(rx_err),
        .rx_dma_eob(rx_dma_eob), .tx_empty(tx_empty),
        .tx_dma_eob(tx_dma_eob), .pend_clr(pend_clr),
        .addr_pend(addr_pend), .data_fwd(data_fwd), .irq_vec(irq_vec)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        rx_valid = 0; rx_data = 0; rx_bit8 = 0; brk_det = 0;
        rx_err = 0; rx_dma_eob = 0; tx_empty = 0; tx_dma_eob = 0;
        pend_clr = 0;
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // drive one character; on return outputs reflect it
    task automatic send(input logic [7:0] d, input logic b8);
        @(negedge clk);
        rx_valid = 1; rx_data = d; rx_bit8 = b8;
        @(negedge clk);
        rx_valid = 0; rx_bit8 = 0;
    endtask

    task automatic test_reset();
        chk(addr_pend, 0, "R1 pend");
        chk(data_fwd, 0, "R1 fwd");
        chk(irq_vec, 8'h00, "R1 vec");
        send(8'h00, 1'b1); // compare byte 0, ninth-bit mode
        chk(addr_pend, 1, "R1 default compare/mode");
        @(negedge clk); pend_clr = 1; @(negedge clk); pend_clr = 0;
    endtask

    task automatic test_config();
        wr(2'd0, 8'h5A);
        wr(2'd1, 8'hAF);
        chk(irq_vec, 8'hA8 | {5'd0, 2'b01, 1'b0}, "R2 R8 base loaded"); // code 01 from R1 match
        wr(2'd2, 8'h00);
    endtask

    task automatic test_ninth();
        send(8'h41, 1'b0);
        chk(data_fwd, 0, "R4 data dropped before match");
        send(8'h33, 1'b1);
        chk(addr_pend, 0, "R3 mismatch no pend");
        send(8'h5A, 1'b1);
        chk(addr_pend, 1, "R3 match sets pend");
        chk(data_fwd, 0, "R3 address not forwarded");
        chk(irq_vec, 8'hAA, "R9 match code 01");
        send(8'h42, 1'b0);
        chk(data_fwd, 1, "R4 data forwarded");
        chk(irq_vec, 8'hAC, "R9 rx data code 10");
        send(8'h11, 1'b1);
        chk(addr_pend, 0, "R3 mismatch clears pend");
        chk(irq_vec, 8'hAC, "R10 code holds");
        send(8'h43, 1'b0);
        chk(data_fwd, 0, "R4 data dropped after clear");
    endtask

    task automatic test_clear();
        send(8'h5A, 1'b1);
        @(negedge clk); pend_clr = 1;
        @(negedge clk); pend_clr = 0;
        chk(addr_pend, 0, "R7 software clear");
        @(negedge clk);
        pend_clr = 1; rx_valid = 1; rx_data = 8'h5A; rx_bit8 = 1;
        @(negedge clk);
        pend_clr = 0; rx_valid = 0; rx_bit8 = 0;
        chk(addr_pend, 1, "R7 match beats clear");
    endtask

    task automatic test_break();
        wr(2'd2, 8'h01);
        chk(addr_pend, 0, "R11 mode write clears pend");
        send(8'h5A, 1'b0);
        chk(addr_pend, 0, "R5 no break, not address");
        chk(data_fwd, 0, "R4 dropped in break mode");
        @(negedge clk); brk_det = 1;
        @(negedge clk); brk_det = 0;
        chk(irq_vec, 8'hAA, "R9 break code 01");
        send(8'h5A, 1'b0);
        chk(addr_pend, 1, "R5 char after break is address");
        chk(data_fwd, 0, "R5 address not forwarded");
        send(8'h5A, 1'b0);
        chk(data_fwd, 1, "R5 next char is data");
        @(negedge clk); brk_det = 1;
        @(negedge clk); brk_det = 0;
        send(8'h20, 1'b1);
        chk(addr_pend, 0, "R5 mismatch after break");
        // arm then leave mode: armed state must be cleared
        @(negedge clk); brk_det = 1;
        @(negedge clk); brk_det = 0;
        wr(2'd2, 8'h00);
        wr(2'd2, 8'h01);
        send(8'h5A, 1'b0);
        chk(addr_pend, 0, "R11 armed cleared by mode write");
    endtask

    task automatic test_search();
        wr(2'd2, 8'h02);
        send(8'h10, 1'b0);
        chk(data_fwd, 1, "R6 every char forwarded");
        chk(addr_pend, 0, "R6 no match");
        send(8'h5A, 1'b0);
        chk(addr_pend, 1, "R6 match sets pend");
        chk(data_fwd, 1, "R6 match char forwarded");
        send(8'h10, 1'b1);
        chk(addr_pend, 1, "R6 mismatch keeps pend");
        wr(2'd2, 8'h03);
        send(8'h77, 1'b0);
        chk(data_fwd, 1, "R6 code 3 searches");
    endtask

    task automatic test_priority();
        @(negedge clk); rx_err = 3'b010; brk_det = 1; tx_empty = 1;
        @(negedge clk); rx_err = 0;
        chk(irq_vec, 8'hA8, "R9 error first");
        @(negedge clk); brk_det = 0; rx_dma_eob = 1;
        chk(irq_vec, 8'hAA, "R9 break over tx");
        @(negedge clk); rx_dma_eob = 0; tx_empty = 0; tx_dma_eob = 1;
        chk(irq_vec, 8'hAC, "R9 rx dma over tx");
        @(negedge clk); tx_dma_eob = 0;
        chk(irq_vec, 8'hAE, "R9 tx code 11");
        wr(2'd1, 8'hF8);
        chk(irq_vec, 8'hFE, "R8 new base, code kept");
        chk(irq_vec & 1, 0, "R8 bit0 zero");
    endtask

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        test_reset();
        test_config();
        test_ninth();
        test_clear();
        test_break();
        test_search();
        test_priority();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule